// File: doc/BRIEF.md
# Phase-Modulated Numerically Controlled Oscillator

This block is the digital core of a direct digital synthesizer. A 32-bit phase accumulator advances on every clock by the active frequency word, plus one more when the carry input is high. A carry-out from a lower-order stage can drive that input, so two stages together give 64-bit frequency resolution. A 12-bit phase offset is added to the most significant accumulator bits, giving a 13-bit table phase. That phase reads a quarter-wave magnitude table. The two top phase bits fold the quadrant and set the sign. The result is a signed sample whose 10 most significant bits go to an external DAC.

Frequency and phase words pass through fixed-length delay lines before they take effect. A frequency change therefore reaches the output a fixed 20 clocks after its load pulse, and a phase change a fixed 13 clocks after its load pulse. The sine-select input picks sine or cosine by adding a quarter cycle to the table phase. After reset the accumulator always starts at zero, whatever the select input is set to. Two instances sharing clock, reset and load pulses, one in each mode, therefore give a quadrature pair.

Top module: `nco_core`

## Requirements
- R1: After `rst_ni` is released, with `carry_i` low and no load pulse, `amp_o` by the seventh rising edge equals the zero-phase value: 0 in sine mode, 511 in cosine mode. It then holds that value.
- R2: The accumulator A is updated on every edge as A <= A + F + `carry_i`, modulo 2^32, where F is the active frequency word. The table phase is A[31:19] plus the offset term plus the select term, modulo 8192.
- R3: With `carry_i` high, the accumulator advances by one more than the active word. For example, a word of 0x0007FFFF with the carry high steps the table phase by exactly 1 per clock.
- R4: The active 12-bit phase offset P enters the table phase as 2*P, so P counts in units of 2^-12 of a cycle.
- R5: For table phase x, let k = x[10:0] and u = k when x[11]=0, else u = 2048-k. The magnitude is floor(2047*16*u*(4096-u) / (5*4096^2 - 4*u*(4096-u))). This gives 2047 at u=2048 and 0 at u=0.
- R6: `sine_sel_i`=1 selects sine; `sine_sel_i`=0 adds 2048 (a quarter cycle) to the table phase for cosine. A change of the select reaches `amp_o` three edges later.
- R7: A frequency word sampled with `freq_load_i` high at edge E first affects `amp_o` after edge E+20. After edge E+19 the output still reflects the old word.
- R8: A phase word sampled with `phase_load_i` high at edge E first affects `amp_o` after edge E+13. After edge E+12 the output still reflects the old offset.
- R9: When table phase bit 12 is 1 the sample is the negated magnitude. The 12-bit two's-complement sample is arithmetically shifted right by 2 to form the 10-bit `amp_o`, so the quarter points give 511 and -512.
- R10: `freq_word_i` and `phase_word_i` have no effect while their load pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_word_i | input | 32 | Frequency word |
| freq_load_i | input | 1 | Frequency load pulse, one clock high |
| phase_word_i | input | 12 | Phase offset word |
| phase_load_i | input | 1 | Phase load pulse, one clock high |
| carry_i | input | 1 | Carry into the accumulator, for cascading |
| sine_sel_i | input | 1 | 1 = sine, 0 = cosine |
| amp_o | output | 10 | Two's-complement amplitude sample for the DAC |

## Verification
The accumulator-hold and carry properties assume `carry_i` and `freq_load_i` are driven from the clock domain, so they are stable at every rising edge. The bench changes all inputs on the falling edge and holds each load pulse for exactly one clock. Latency and waveform checks assume loads are issued only after the seven-edge settling time that follows reset. Each stimulus vector therefore starts from a fresh reset, waits those seven edges, and only then applies its frequency, phase and carry together.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic {WAVE_COS = 1'b0, WAVE_SIN = 1'b1} wave_sel_e;

  // Rational sine approximation over a half cycle of 2*qn steps, evaluated for u in [0, qn]
  function automatic int unsigned quarter_mag(int unsigned u, int unsigned qn,
                                              int unsigned amax);
    longint unsigned m, p, num, den;
    m   = 2 * longint'(qn);
    p   = longint'(u) * (m - longint'(u));
    num = 16 * longint'(amax) * p;
    den = 5 * m * m - 4 * p;
    return int'(num / den);
  endfunction

endpackage

// File: rtl/nco_delay_line.sv
module nco_delay_line #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);

  if (DEPTH == 0) begin : g_bypass
    assign vld_o = vld_i;
    assign dat_o = dat_i;
  end else begin : g_pipe
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic         v_q;
      logic [W-1:0] d_q;
      logic         v_in;
      logic [W-1:0] d_in;
      if (s == 0) begin : g_head
        assign v_in = vld_i;
        assign d_in = dat_i;
      end else begin : g_link
        assign v_in = g_stage[s-1].v_q;
        assign d_in = g_stage[s-1].d_q;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else begin
          v_q <= v_in;
          d_q <= d_in;
        end
      end
    end
    assign vld_o = g_stage[DEPTH-1].v_q;
    assign dat_o = g_stage[DEPTH-1].d_q;
  end

endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int ACC_W = 32,
  parameter int TOP_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [ACC_W-1:0] word_i,
  input  logic             carry_i,
  output logic [TOP_W-1:0] top_o
);

  logic [ACC_W-1:0] freq_act;
  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) freq_act <= '0;
    else if (upd_i) freq_act <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc <= '0;
    else acc <= acc + freq_act + ACC_W'(carry_i);
  end

  assign top_o = acc[ACC_W-1 -: TOP_W];

  // R10
  freq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(freq_act));

  // R1
  acc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_act == '0 && !carry_i) |=> $stable(acc));

  // R3
  carry_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_act == '0 && carry_i) |=> acc != $past(acc));

endmodule

// File: rtl/nco_wave_lut.sv
module nco_wave_lut #(
  parameter int IDX_W = 13,
  parameter int AMP_W = 12,
  parameter int OUT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic [OUT_W-1:0] amp_o
);

  localparam int QN      = 1 << (IDX_W - 2);
  localparam int MAG_W   = AMP_W - 1;
  localparam int AMP_MAX = (1 << MAG_W) - 1;
  localparam int ADDR_W  = IDX_W - 1;
  localparam int SHIFT   = AMP_W - OUT_W;

  logic [MAG_W-1:0] rom [QN+1];

  for (genvar g = 0; g <= QN; g++) begin : g_rom
    assign rom[g] = MAG_W'(nco_pkg::quarter_mag(g, QN, AMP_MAX));
  end

  logic [IDX_W-3:0]  k;
  logic [ADDR_W-1:0] addr;
  assign k    = idx_i[IDX_W-3:0];
  // odd quadrants read the table backwards
  assign addr = idx_i[IDX_W-2] ? (ADDR_W'(QN) - ADDR_W'(k)) : ADDR_W'(k);

  logic [MAG_W-1:0] mag_q;
  logic             neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
      neg_q <= 1'b0;
    end else begin
      mag_q <= rom[addr];
      neg_q <= idx_i[IDX_W-1];
    end
  end

  logic signed [AMP_W-1:0] amp_full;
  assign amp_full = neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) amp_o <= '0;
    else amp_o <= OUT_W'(amp_full >>> SHIFT);
  end

  // R5 R6
  cos_peak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == IDX_W'(QN)) |=> mag_q == MAG_W'(AMP_MAX));

  // R9
  neg_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (neg_q && mag_q != '0) |=> amp_o[OUT_W-1]);

  // R9
  pos_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !neg_q |=> !amp_o[OUT_W-1]);

endmodule

// File: rtl/nco_core.sv
module nco_core #(
  parameter int ACC_W     = 32,
  parameter int POFF_W    = 12,
  parameter int IDX_W     = 13,
  parameter int AMP_W     = 12,
  parameter int OUT_W     = 10,
  parameter int FREQ_LAT  = 20,
  parameter int PHASE_LAT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ACC_W-1:0]  freq_word_i,
  input  logic              freq_load_i,
  input  logic [POFF_W-1:0] phase_word_i,
  input  logic              phase_load_i,
  input  logic              carry_i,
  input  logic              sine_sel_i,
  output logic [OUT_W-1:0]  amp_o
);

  import nco_pkg::*;

  // stages after the active registers: accumulator/offset, index, table, output
  localparam int FREQ_DLY  = FREQ_LAT - 4;
  localparam int PHASE_DLY = PHASE_LAT - 3;
  localparam int QUARTER   = 1 << (IDX_W - 2);
  localparam int POFF_SH   = IDX_W - POFF_W;

  logic             fd_vld;
  logic [ACC_W-1:0] fd_word;
  logic [IDX_W-1:0] acc_top;

  nco_delay_line #(.W(ACC_W), .DEPTH(FREQ_DLY)) u_fdly (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .vld_i (freq_load_i), .dat_i(freq_word_i),
    .vld_o (fd_vld), .dat_o(fd_word)
  );

  nco_accum #(.ACC_W(ACC_W), .TOP_W(IDX_W)) u_acc (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .upd_i (fd_vld), .word_i(fd_word),
    .carry_i(carry_i), .top_o(acc_top)
  );

  logic              pd_vld;
  logic [POFF_W-1:0] pd_word;
  logic [POFF_W-1:0] poff_act;

  nco_delay_line #(.W(POFF_W), .DEPTH(PHASE_DLY)) u_pdly (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .vld_i (phase_load_i), .dat_i(phase_word_i),
    .vld_o (pd_vld), .dat_o(pd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) poff_act <= '0;
    else if (pd_vld) poff_act <= pd_word;
  end

  wave_sel_e        wave_sel;
  logic [IDX_W-1:0] idx_q;
  assign wave_sel = wave_sel_e'(sine_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else idx_q <= acc_top + (IDX_W'(poff_act) << POFF_SH)
                  + ((wave_sel == WAVE_SIN) ? '0 : IDX_W'(QUARTER));
  end

  nco_wave_lut #(.IDX_W(IDX_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_lut (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .idx_i (idx_q), .amp_o(amp_o)
  );

  // R10
  poff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_vld |=> $stable(poff_act));

endmodule

// File: tb/nco_core_test.sv
module nco_core_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] freq_word = '0;
  logic        freq_load = 1'b0;
  logic [11:0] phase_word = '0;
  logic        phase_load = 1'b0;
  logic        carry = 1'b0;
  logic        sine_sel = 1'b1;
  logic [9:0]  amp;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nco_core uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .freq_word_i(freq_word), .freq_load_i(freq_load),
    .phase_word_i(phase_word), .phase_load_i(phase_load),
    .carry_i(carry), .sine_sel_i(sine_sel), .amp_o(amp)
  );

  // expected output from R2 R4 R5 R6 R9
  function automatic logic [9:0] exp_amp(logic [31:0] acc, logic [11:0] p, logic sel);
    logic [12:0] x;
    longint u, q, m;
    logic signed [11:0] s;
    x = acc[31:19] + {p, 1'b0} + (sel ? 13'd0 : 13'd2048);
    u = x[11] ? (2048 - longint'(x[10:0])) : longint'(x[10:0]);
    q = u * (4096 - u);
    m = (16 * 2047 * q) / (5 * 4096 * 4096 - 4 * q);
    s = x[12] ? -12'(m) : 12'(m);
    return s[11:2];
  endfunction

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: amp_o=%0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic do_reset(logic sel);
    rst_ni = 1'b0; freq_load = 1'b0; phase_load = 1'b0; carry = 1'b0;
    sine_sel = sel; freq_word = '0; phase_word = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (7) @(negedge clk);
    check("R1 reset value", amp, sel ? 10'd0 : 10'd511);
  endtask

  // returns on the falling edge right after the sampling edge E
  task automatic load(logic [31:0] f, logic c, logic [11:0] p, logic do_f, logic do_p);
    freq_word = f; phase_word = p; carry = c;
    freq_load = do_f; phase_load = do_p;
    @(negedge clk);
    freq_load = 1'b0; phase_load = 1'b0;
  endtask

  localparam int NV = 6;
  localparam logic [31:0] VF [NV] = '{32'h0008_0000, 32'h0007_FFFF, 32'h4000_0000,
                                      32'h8000_0000, 32'h1234_5678, 32'hFFF8_0000};
  localparam logic        VC [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [11:0] VP [NV] = '{12'h000, 12'h000, 12'h200, 12'h400, 12'hABC, 12'h800};
  localparam logic        VS [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  initial begin
    for (int i = 0; i < NV; i++) begin
      do_reset(VS[i]);
      load(VF[i], VC[i], VP[i], 1'b1, 1'b1);
      repeat (19) @(negedge clk);
      // R7: old word still in effect; carry alone ran for 17 edges
      check("R7 before freq change", amp, exp_amp(32'd17 * VC[i], VP[i], VS[i]));
      for (int j = 0; j < 4; j++) begin
        logic [31:0] a;
        @(negedge clk);
        a = 32'd17 * VC[i] + 32'(j + 1) * (VF[i] + 32'(VC[i]));
        check(VC[i] ? "R3 carry step" : "R2 R4 R5 R6 R7 vector", amp,
              exp_amp(a, VP[i], VS[i]));
      end
    end

    // R8: phase latency
    do_reset(1'b1);
    load('0, 1'b0, 12'h400, 1'b0, 1'b1);
    repeat (12) @(negedge clk);
    check("R8 before phase change", amp, 10'd0);
    @(negedge clk);
    check("R8 phase change", amp, 10'd511);

    // R9: remaining quadrant points
    load('0, 1'b0, 12'h800, 1'b0, 1'b1);
    repeat (13) @(negedge clk);
    check("R9 half cycle", amp, 10'd0);
    load('0, 1'b0, 12'hC00, 1'b0, 1'b1);
    repeat (13) @(negedge clk);
    check("R9 three quarter", amp, 10'h200);

    // R6: live select switch, three edges
    do_reset(1'b1);
    sine_sel = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 select not yet", amp, 10'd0);
    @(negedge clk);
    check("R6 select to cosine", amp, 10'd511);

    // R10: words without load pulses; R1 hold
    do_reset(1'b1);
    freq_word = 32'h1234_5678;
    phase_word = 12'h555;
    repeat (40) @(negedge clk);
    check("R10 words ignored", amp, 10'd0);
    check("R1 hold", amp, exp_amp(32'd0, 12'h000, 1'b1));
    load(32'h1234_5678, 1'b0, 12'h555, 1'b0, 1'b1);
    repeat (13) @(negedge clk);
    check("R10 phase after load", amp, exp_amp(32'd0, 12'h555, 1'b1));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule